// File: doc/BRIEF.md
# Grouped Change-of-State Input Port

This block watches 48 read-only digital input lines, arranged as six groups of eight, and raises an interrupt when any line in an armed group toggles. A host reaches it through a small byte-wide window of eight addresses using single-cycle read and write strobes. Six of the addresses return the current, synchronised level of one group each. The last address arms groups when written. When read, it returns which groups have fired, together with an active-low summary of the interrupt request.

Every line first passes through a two-flop synchroniser. After that, the block compares it with its value on the previous clock, so a toggle in either direction counts. A toggle latches a sticky flag for its group, provided that group is armed. The flags stay set until the host reads the status address or disarms the group. The interrupt output is high while any flag is set.

Top module: `cos_input_port`

## Requirements
- R1: A read of offset 0, 1, 2, 4, 5 or 6 returns the synchronised level of group 0, 1, 2, 3, 4 or 5 respectively. Bit n of the byte is line 8*g+n of `line_in`. Read data appears on `bus_rdata` one clock after the read strobe, and a line change is visible there no later than three clocks after it is applied.
- R2: Offset 3 always reads 0x00. A write to any offset other than 7 changes no armed group.
- R3: After reset no group is armed. Line changes then latch nothing and `irq` stays low.
- R4: Writing offset 7 arms group k when data bit k is 1, for k from 0 to 5. In an armed group, a rising or a falling change of any line latches that group's flag.
- R5: A change on a line in an unarmed group latches no flag.
- R6: A read of offset 7 returns the group flags in bits 5..0. Bit 6 is 0 while `irq` is high and 1 otherwise, and bit 7 is 0.
- R7: A read of offset 7 clears all group flags, and `irq` falls on the next clock. A change that is detected in the same clock as that read stays latched.
- R8: Writing 0 to an armed group's bit at offset 7 clears that group's flag.
- R9: `irq` is high exactly when at least one group flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_addr | input | 3 | Byte offset within the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| line_in | input | 48 | Asynchronous input lines |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle. They also assume that the strobes, the offset and the write data are known whenever reset is inactive. The input lines may change at any time, because they are synchronised before any property looks at them. The bench changes all strobes and lines only on the falling clock edge and raises at most one strobe per transaction. It also drives every input to a defined value from time zero, so the assumed conditions always hold.

// File: rtl/cos_pkg.sv
package cos_pkg;
   localparam int BUS_W     = 8;
   localparam int ADDR_W    = 3;
   localparam int MAX_GRP   = 6;
   localparam logic [ADDR_W-1:0] STAT_ADDR = 3'd7;
   localparam logic [ADDR_W-1:0] HOLE_ADDR = 3'd3;
   localparam int PEND_N_BIT = 6;

   typedef enum logic [1:0] {SEL_GROUP, SEL_HOLE, SEL_STATUS} sel_e;

   function automatic sel_e decode_sel(input logic [ADDR_W-1:0] a);
      if (a == STAT_ADDR)      return SEL_STATUS;
      else if (a == HOLE_ADDR) return SEL_HOLE;
      else                     return SEL_GROUP;
   endfunction

   // Group index for a data offset: offsets above the hole shift down by one.
   function automatic logic [ADDR_W-1:0] group_of(input logic [ADDR_W-1:0] a);
      return (a > HOLE_ADDR) ? a - 3'd1 : a;
   endfunction
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
   parameter int WIDTH  = 48,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);
   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[0] <= '0;
               else        stage_q[0] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/cos_edge_detect.sv
module cos_edge_detect #(
   parameter int NUM_GROUPS = 6,
   parameter int GROUP_W    = 8,
   localparam int LINES     = NUM_GROUPS * GROUP_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [LINES-1:0]      lines_sync,
   output logic [NUM_GROUPS-1:0] grp_edge
);
   logic [LINES-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lines_sync;
   end

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
         assign grp_edge[g] = |(lines_sync[g*GROUP_W +: GROUP_W] ^
                                prev_q[g*GROUP_W +: GROUP_W]);
      end
   endgenerate
endmodule

// File: rtl/cos_ctrl.sv
module cos_ctrl
   import cos_pkg::*;
#(
   parameter int NUM_GROUPS = 6,
   parameter int GROUP_W    = 8,
   localparam int LINES     = NUM_GROUPS * GROUP_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [BUS_W-1:0]      bus_wdata,
   output logic [BUS_W-1:0]      bus_rdata,
   input  logic [LINES-1:0]      lines_sync,
   input  logic [NUM_GROUPS-1:0] grp_edge,
   output logic [NUM_GROUPS-1:0] arm_q,
   output logic [NUM_GROUPS-1:0] flag_q,
   output logic                  irq
);
   sel_e                  sel;
   logic                  stat_wr, stat_rd;
   logic [NUM_GROUPS-1:0] arm_next, flag_next;
   logic [BUS_W-1:0]      rd_mux, status_byte;
   logic [ADDR_W-1:0]     gidx;
   logic                  irq_q;

   assign sel     = decode_sel(bus_addr);
   assign stat_wr = bus_wr && (sel == SEL_STATUS);
   assign stat_rd = bus_rd && (sel == SEL_STATUS);
   assign gidx    = group_of(bus_addr);

   always_comb begin
      arm_next = arm_q;
      if (stat_wr) arm_next = bus_wdata[NUM_GROUPS-1:0];
   end

   // Sticky flags: cleared by a status read, set by armed edges, dropped on disarm.
   always_comb begin
      flag_next = stat_rd ? '0 : flag_q;
      flag_next = flag_next | (grp_edge & arm_q);
      flag_next = flag_next & arm_next;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm_q  <= '0;
         flag_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         arm_q  <= arm_next;
         flag_q <= flag_next;
         irq_q  <= |flag_next;
      end
   end

   always_comb begin
      status_byte = '0;
      status_byte[NUM_GROUPS-1:0] = flag_q;
      status_byte[PEND_N_BIT]     = ~irq_q;
   end

   always_comb begin
      rd_mux = '0;
      unique case (sel)
         SEL_STATUS: rd_mux = status_byte;
         SEL_HOLE:   rd_mux = '0;
         default: begin
            for (int g = 0; g < NUM_GROUPS; g++)
               if (gidx == ADDR_W'(g))
                  rd_mux = lines_sync[g*GROUP_W +: GROUP_W];
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   assign irq = irq_q;
endmodule

// File: rtl/cos_input_port.sv
module cos_input_port
   import cos_pkg::*;
#(
   parameter int NUM_GROUPS  = 6,
   parameter int GROUP_W     = 8,
   parameter int SYNC_STAGES = 2,
   localparam int LINES      = NUM_GROUPS * GROUP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [2:0]        bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [LINES-1:0]  line_in,
   output logic              irq
);
   generate
      if (GROUP_W != BUS_W) begin : g_bad_width
         $error("GROUP_W must equal the bus byte width");
      end
      if (NUM_GROUPS < 1 || NUM_GROUPS > MAX_GRP) begin : g_bad_groups
         $error("NUM_GROUPS must be 1..6");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [LINES-1:0]      lines_sync;
   logic [NUM_GROUPS-1:0] grp_edge;
   logic [NUM_GROUPS-1:0] arm_q;
   logic [NUM_GROUPS-1:0] flag_q;

   cos_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (line_in),
      .d_out (lines_sync)
   );

   cos_edge_detect #(.NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W)) u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .lines_sync (lines_sync),
      .grp_edge   (grp_edge)
   );

   cos_ctrl #(.NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_wr     (bus_wr),
      .bus_rd     (bus_rd),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .lines_sync (lines_sync),
      .grp_edge   (grp_edge),
      .arm_q      (arm_q),
      .flag_q     (flag_q),
      .irq        (irq)
   );
endmodule

// File: rtl/cos_input_port_chk.sv
module cos_input_port_chk #(
   parameter int NUM_GROUPS = 6
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_wr,
   input logic                  bus_rd,
   input logic [2:0]            bus_addr,
   input logic [7:0]            bus_wdata,
   input logic [NUM_GROUPS-1:0] grp_edge,
   input logic [NUM_GROUPS-1:0] arm_q,
   input logic [NUM_GROUPS-1:0] flag_q,
   input logic                  irq
);
   // R9
   irq_matches_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (flag_q != '0));

   // R5
   flag_only_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q & ~arm_q) == '0);

   // R4
   armed_edge_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((grp_edge & arm_q) != '0 && !(bus_wr && bus_addr == 3'd7))
      |=> ((flag_q & $past(grp_edge & arm_q)) == $past(grp_edge & arm_q)));

   // R7
   status_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 3'd7)
      |=> ((flag_q & ~$past(grp_edge & arm_q)) == '0));

   // R8
   disarm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd7)
      |=> ((flag_q & ~$past(bus_wdata[NUM_GROUPS-1:0])) == '0));

   // R2
   other_write_keeps_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr != 3'd7) |=> $stable(arm_q));
endmodule

bind cos_input_port cos_input_port_chk #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .grp_edge  (grp_edge),
   .arm_q     (arm_q),
   .flag_q    (flag_q),
   .irq       (irq)
);

// File: tb/tb_cos_input_port.sv
module tb_cos_input_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [47:0] line_in = '0;
   logic        irq;

   int checks = 0;
   int errors = 0;

   cos_input_port dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .line_in(line_in), .irq(irq)
   );

   always #4 clk = ~clk;

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   function automatic logic [2:0] offs(input int g);
      return (g < 3) ? 3'(g) : 3'(g + 1);
   endfunction

   task automatic t_reset();
      logic [7:0] d;
      check("R3 irq after reset", {7'd0, irq}, 8'h00);
      bus_read(3'd7, d);
      check("R6 status after reset", d, 8'h40);
      line_in = 48'hFFFF_FFFF_FFFF;
      settle();
      check("R3 unarmed changes no irq", {7'd0, irq}, 8'h00);
      bus_read(3'd7, d);
      check("R3 unarmed status empty", d, 8'h40);
   endtask

   task automatic t_group_read();
      logic [7:0] d;
      @(negedge clk);
      line_in = 48'hA5C3_1E77_0F81;
      settle();
      for (int g = 0; g < 6; g++) begin
         bus_read(offs(g), d);
         check($sformatf("R1 group %0d level", g), d, line_in[g*8 +: 8]);
      end
   endtask

   task automatic t_hole_offset();
      logic [7:0] d;
      bus_read(3'd3, d);
      check("R2 hole reads zero", d, 8'h00);
      bus_write(3'd3, 8'hFF);
      bus_write(3'd0, 8'hFF);
      @(negedge clk);
      line_in = ~line_in;
      settle();
      check("R2 other writes arm nothing", {7'd0, irq}, 8'h00);
      bus_read(3'd7, d);
      check("R2 status still empty", d, 8'h40);
   endtask

   task automatic t_both_edges();
      logic [7:0] d;
      bus_write(3'd7, 8'h04);
      @(negedge clk);
      line_in[16+3] = ~line_in[16+3];
      settle();
      check("R4 rise/fall latches group 2 irq", {7'd0, irq}, 8'h01);
      bus_read(3'd7, d);
      check("R6 status group 2 pending", d, 8'h04);
      bus_read(3'd7, d);
      check("R7 read cleared status", d, 8'h40);
      check("R7 irq low after read", {7'd0, irq}, 8'h00);
      @(negedge clk);
      line_in[16+3] = ~line_in[16+3];
      settle();
      bus_read(3'd7, d);
      check("R4 opposite edge latches group 2", d, 8'h04);
   endtask

   task automatic t_disabled_group();
      logic [7:0] d;
      bus_write(3'd7, 8'h21);
      @(negedge clk);
      line_in[8 +: 8] = ~line_in[8 +: 8];
      line_in[24 +: 8] = ~line_in[24 +: 8];
      settle();
      check("R5 unarmed groups no irq", {7'd0, irq}, 8'h00);
      @(negedge clk);
      line_in[47] = ~line_in[47];
      line_in[0]  = ~line_in[0];
      settle();
      bus_read(3'd7, d);
      check("R5 only armed groups 0 and 5 flagged", d, 8'h21);
   endtask

   task automatic t_same_cycle();
      logic [7:0] d;
      bus_read(3'd7, d);
      @(negedge clk);
      line_in[40] = ~line_in[40];
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 3'd7;
      @(negedge clk);
      bus_rd = 1'b0;
      check("R7 read in edge cycle shows old", bus_rdata, 8'h40);
      check("R9 irq kept by same-cycle edge", {7'd0, irq}, 8'h01);
      bus_read(3'd7, d);
      check("R7 same-cycle edge stays latched", d, 8'h20);
   endtask

   task automatic t_disarm_clears();
      logic [7:0] d;
      @(negedge clk);
      line_in[1]  = ~line_in[1];
      line_in[41] = ~line_in[41];
      settle();
      bus_write(3'd7, 8'h01);
      @(negedge clk);
      check("R9 irq stays with group 0", {7'd0, irq}, 8'h01);
      bus_read(3'd7, d);
      check("R8 disarmed group 5 dropped", d, 8'h01);
      bus_write(3'd7, 8'h00);
      @(negedge clk);
      check("R8 disarm all drops irq", {7'd0, irq}, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_group_read();
      t_hole_offset();
      t_both_edges();
      t_disabled_group();
      t_same_cycle();
      t_disarm_clears();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule